// File: doc/BRIEF.md
# Integrating ADC cycle sequencer

This block runs the integration cycles of four integrating converter channels that work side by side. Each channel gives one count-enable bit per clock. The block holds one saturating 16-bit accumulator per channel. All four accumulators share a single integration window, so they open and close on the same clock edge. When a window closes, the four counts are latched together into a staging buffer. From there they move as one transfer into the result registers that software reads. The analog front end and the serial register access are not part of this block.

Four timing modes choose how a window starts and ends:

- **Free-running** (mode 0): windows of a programmed length follow each other with no gap.
- **Sync-started single shot** (mode 1): a rising edge on the sync input starts one window of the programmed length.
- **Software-gated** (mode 2): a window stays open while the enable bit is set.
- **Pulse-bounded** (mode 3): a window spans a programmed number of sync pulses.

A valid flag marks fresh results and a read strobe clears it. A busy output shows that a window is open.

Top module: `integ_cycle_seq`

## Requirements
- R1: Within one window, every channel whose count-enable bit is held high has the same count. Every channel whose bit is held low reads 0.
- R2: `mode`=0 (free-running) gives windows of 12, 100 or 400 ticks for `len_sel` = 0, 1 or 2. One tick is PRESCALE clocks (default 2). Windows repeat back to back and `busy` stays high between them.
- R3: In modes 0 and 1, `len_sel`=3 starts no window, and `busy` stays low.
- R4: In `mode`=1, one rising edge on `sync_in` starts exactly one window of the programmed length. After it, `busy` goes low and stays low.
- R5: In `mode`=2, a window opens on the first clock after `adc_en` is seen high and closes on the first clock after `adc_en` is seen low. Holding `adc_en` for H clocks gives a count of H.
- R6: In `mode`=3, a window opens on one rising edge of `sync_in` and closes on the N-th rising edge after it, where N = `pulse_cnt`. A `pulse_cnt` of 0 acts as 1.
- R7: An accumulator stops at 16'hFFFF and does not wrap.
- R8: Every accumulator restarts from zero at the start of each window, so each result covers one window only.
- R9: `data_out` changes only in a transfer, and all four channels change in the same clock. Channel i is `data_out[16*i+15:16*i]`.
- R10: `valid` goes high on each transfer. It is low on the clock after any clock where `rd_strobe` is high.
- R11: No transfer happens while `rd_strobe` is high. A pending transfer takes place on the first clock edge at which `rd_strobe` is low.
- R12: After reset, `busy` and `valid` are low and `data_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Timing mode: 0 free-running, 1 sync single shot, 2 enable-gated, 3 pulse-bounded |
| len_sel | input | 2 | Internal window length code: 12/100/400 ticks; 3 is reserved |
| adc_en | input | 1 | Software enable bit for mode 2 |
| sync_in | input | 1 | Asynchronous sync input; only rising edges are used |
| pulse_cnt | input | 4 | Number of sync pulses that bound a window in mode 3 |
| ch_inc | input | 4 | Per-channel count-enable bits |
| rd_strobe | input | 1 | Read strobe: clears valid and holds off transfers |
| data_out | output | 64 | Four 16-bit channel results |
| valid | output | 1 | Fresh results are held |
| busy | output | 1 | An integration window is open |

## Verification
The main function is exercised with mixed channel-enable patterns (all on, alternating bits, adjacent pairs) across all four modes and all three internal lengths. Each result must match the window length in clocks while the idle channels read zero. This separates a wrong window length from a channel that is miscounted or cross-wired. Pulse-bounded windows use two pulse spacings, including a count of zero, which tells an off-by-one in edge counting apart from a wrong spacing. Back-to-back free-running results, a read held across the end of a window, a reserved length code and a very long gated window each isolate one of the following: the clear at the start of a window, the deferral of a transfer, start suppression, and saturation.

// File: rtl/icq_pkg.sv
// Shared definitions for the integrating cycle sequencer.
// Assumes the mode code is driven by a static configuration field.
package icq_pkg;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_GATED  = 2'd2,
        MODE_PULSE  = 2'd3
    } cyc_mode_e;

    // Window length in ticks for a length code; 0 marks the reserved code.
    function automatic int ticks_for(input logic [1:0] code);
        case (code)
            2'd0:    return 12;
            2'd1:    return 100;
            2'd2:    return 400;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/icq_sync_edge.sv
// Two-flop synchronizer followed by a rising-edge detector.
// Assumes the input is asynchronous and each level lasts at least two clocks.
module icq_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic rise
);
    logic s1, s2, s3;

    // Resynchronize the input and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= d_async;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
endmodule

// File: rtl/icq_chan_acc.sv
// One channel accumulator: it counts enable bits while the window is open
// and saturates at all ones.
// A clear pulse restarts it with the current bit.
// Assumes clr is only asserted while the window is open.
module icq_chan_acc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         integ,
    input  logic         inc,
    output logic [W-1:0] acc
);
    // Restart on clear; otherwise add the enable bit unless already full.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= {{(W-1){1'b0}}, inc};
        else if (integ && inc && (acc != {W{1'b1}}))
            acc <= acc + 1'b1;
    end
endmodule

// File: rtl/icq_cycle_ctrl.sv
// Window controller: it decides when the shared integration window opens and
// closes for each mode.
// It emits a clear pulse at each start and a done pulse at each end.
// Assumes the mode and length fields stay static while a window is open.
module icq_cycle_ctrl
    import icq_pkg::*;
#(
    parameter int PRESCALE = 2,
    parameter int PCW      = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     mode,
    input  logic [1:0]     len_sel,
    input  logic           adc_en,
    input  logic           sync_rise,
    input  logic [PCW-1:0] pulse_cnt,
    output logic           integ,
    output logic           clr,
    output logic           done
);
    localparam int MAXLEN = 400 * PRESCALE;
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    cyc_mode_e      m;
    logic [CNT_W-1:0] cnt, limit;
    logic [PCW-1:0]   edges, npulse;
    logic             len_ok, start_req, end_req;

    assign m      = cyc_mode_e'(mode);
    assign len_ok = (len_sel != 2'd3);
    assign limit  = CNT_W'(ticks_for(len_sel) * PRESCALE);
    assign npulse = (pulse_cnt == '0) ? PCW'(1) : pulse_cnt;

    // Start and end conditions for the selected mode.
    always_comb begin
        case (m)
            MODE_FREE: begin
                start_req = len_ok;
                end_req   = !len_ok || (cnt >= limit - CNT_W'(1));
            end
            MODE_SINGLE: begin
                start_req = len_ok && sync_rise;
                end_req   = !len_ok || (cnt >= limit - CNT_W'(1));
            end
            MODE_GATED: begin
                start_req = adc_en;
                end_req   = !adc_en;
            end
            default: begin
                start_req = sync_rise;
                end_req   = sync_rise &&
                            ({1'b0, edges} + 1'b1 >= {1'b0, npulse});
            end
        endcase
    end

    // Window state, clock counter and sync edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ <= 1'b0;
            clr   <= 1'b0;
            done  <= 1'b0;
            cnt   <= '0;
            edges <= '0;
        end else begin
            clr  <= 1'b0;
            done <= 1'b0;
            if (!integ) begin
                if (start_req) begin
                    integ <= 1'b1;
                    clr   <= 1'b1;
                    cnt   <= '0;
                    edges <= '0;
                end
            end else if (end_req) begin
                done  <= 1'b1;
                cnt   <= '0;
                edges <= '0;
                if (m == MODE_FREE && len_ok)
                    clr <= 1'b1;
                else
                    integ <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
                if (sync_rise)
                    edges <= edges + 1'b1;
            end
        end
    end
endmodule

// File: rtl/icq_result_buf.sv
// Double-buffered result store.
// The done pulse latches every accumulator into a staging buffer. Staging
// then moves to the readable registers as one transfer on a clock with no
// read strobe.
// Assumes done is a single-clock pulse.
module icq_result_buf #(
    parameter int NCH = 4,
    parameter int W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [NCH*W-1:0] acc_flat,
    input  logic             rd_strobe,
    output logic [NCH*W-1:0] data_out,
    output logic             valid
);
    logic [NCH*W-1:0] stage;
    logic             pend;

    // Stage on done; publish when no read is in progress; clear valid on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage    <= '0;
            pend     <= 1'b0;
            data_out <= '0;
            valid    <= 1'b0;
        end else begin
            if (pend && !rd_strobe) begin
                data_out <= stage;
                valid    <= 1'b1;
                pend     <= 1'b0;
            end else if (rd_strobe) begin
                valid <= 1'b0;
            end
            if (done) begin
                stage <= acc_flat;
                pend  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/integ_cycle_seq.sv
// Top of the integrating cycle sequencer: one window controller, one sync
// edge detector, NCH channel accumulators and the double-buffered result
// store.
// Assumes count-enable bits are synchronous to clk.
module integ_cycle_seq #(
    parameter int NCH      = 4,
    parameter int W        = 16,
    parameter int PRESCALE = 2,
    parameter int PCW      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [1:0]       len_sel,
    input  logic             adc_en,
    input  logic             sync_in,
    input  logic [PCW-1:0]   pulse_cnt,
    input  logic [NCH-1:0]   ch_inc,
    input  logic             rd_strobe,
    output logic [NCH*W-1:0] data_out,
    output logic             valid,
    output logic             busy
);
    logic             sync_rise, integ, clr, done;
    logic [NCH*W-1:0] acc_flat;

    icq_sync_edge u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(sync_in), .rise(sync_rise)
    );

    icq_cycle_ctrl #(.PRESCALE(PRESCALE), .PCW(PCW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .len_sel(len_sel),
        .adc_en(adc_en), .sync_rise(sync_rise), .pulse_cnt(pulse_cnt),
        .integ(integ), .clr(clr), .done(done)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        icq_chan_acc #(.W(W)) u_acc (
            .clk(clk), .rst_n(rst_n), .clr(clr), .integ(integ),
            .inc(ch_inc[i]), .acc(acc_flat[i*W +: W])
        );
    end

    icq_result_buf #(.NCH(NCH), .W(W)) u_buf (
        .clk(clk), .rst_n(rst_n), .done(done), .acc_flat(acc_flat),
        .rd_strobe(rd_strobe), .data_out(data_out), .valid(valid)
    );

    assign busy = integ;
endmodule

// File: rtl/icq_checker.sv
// Port-level properties of the integrating cycle sequencer, bound to its top.
module icq_checker #(
    parameter int NCH = 4,
    parameter int W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [1:0]       len_sel,
    input logic             adc_en,
    input logic             rd_strobe,
    input logic [NCH*W-1:0] data_out,
    input logic             valid,
    input logic             busy
);
    // R2: free-running windows follow each other without dropping busy.
    a_r2_free_continuous: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode == 2'd0 && len_sel != 2'd3) |=> busy);

    // R3: the reserved length code never starts an internal window.
    a_r3_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (mode == 2'd0 || mode == 2'd1) && len_sel == 2'd3) |=> !busy);

    // R5: clearing the enable bit closes a gated window on the next clock.
    a_r5_gated_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode == 2'd2 && !adc_en) |=> !busy);

    // R9: published results change only together with a transfer.
    a_r9_atomic_update: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> valid);

    // R10 and R11: a read strobe clears valid and blocks a transfer.
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !valid);
endmodule

bind integ_cycle_seq icq_checker #(.NCH(NCH), .W(W)) i_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .len_sel(len_sel),
    .adc_en(adc_en), .rd_strobe(rd_strobe), .data_out(data_out),
    .valid(valid), .busy(busy)
);

// File: tb/test_integ_cycle_seq.sv
module test_integ_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd2;
    logic [1:0]  len_sel = 2'd0;
    logic        adc_en = 1'b0;
    logic        sync_in = 1'b0;
    logic [3:0]  pulse_cnt = 4'd0;
    logic [3:0]  ch_inc = 4'd0;
    logic        rd_strobe = 1'b0;
    logic [63:0] data_out;
    logic        valid, busy;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    integ_cycle_seq i_integ_cycle_seq (
        .clk(clk), .rst_n(rst_n), .mode(mode), .len_sel(len_sel),
        .adc_en(adc_en), .sync_in(sync_in), .pulse_cnt(pulse_cnt),
        .ch_inc(ch_inc), .rd_strobe(rd_strobe), .data_out(data_out),
        .valid(valid), .busy(busy)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [1:0]  len;
        logic [3:0]  inc;
        logic [3:0]  pcnt;
        logic [15:0] arg;   // gated hold clocks or sync spacing
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd0, 4'b1111, 4'd0, 16'd0,  16'd24},   // R2 R1
        '{2'd0, 2'd1, 4'b0101, 4'd0, 16'd0,  16'd200},  // R2 R1
        '{2'd0, 2'd2, 4'b1010, 4'd0, 16'd0,  16'd800},  // R2 R1
        '{2'd1, 2'd0, 4'b0011, 4'd0, 16'd0,  16'd24},   // R4
        '{2'd2, 2'd0, 4'b1001, 4'd0, 16'd37, 16'd37},   // R5
        '{2'd3, 2'd0, 4'b1111, 4'd2, 16'd10, 16'd20},   // R6
        '{2'd3, 2'd0, 4'b0110, 4'd0, 16'd7,  16'd7},    // R6 zero count
        '{2'd2, 2'd0, 4'b1111, 4'd0, 16'd5,  16'd5}     // R5 R1
    };

    task automatic check(input logic ok, input string tag,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ch(input int i);
        return data_out[16*i +: 16];
    endfunction

    task automatic sync_pulses(input int n, input int spacing);
        for (int k = 0; k < n; k++) begin
            sync_in = 1'b1;
            repeat (3) @(negedge clk);
            sync_in = 1'b0;
            repeat (spacing - 3) @(negedge clk);
        end
    endtask

    task automatic wait_valid(input string tag);
        int t = 0;
        while (!valid && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(valid, tag, valid, 1);
    endtask

    task automatic idle_down();
        mode   = 2'd2;
        adc_en = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic check_chans(input logic [3:0] inc, input logic [15:0] exp,
                               input string tag);
        for (int i = 0; i < 4; i++)
            check(ch(i) == (inc[i] ? exp : 16'd0), tag, ch(i),
                  inc[i] ? exp : 16'd0);
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R12: reset state
        check(busy == 1'b0, "R12 busy", busy, 0);
        check(valid == 1'b0, "R12 valid", valid, 0);
        check(data_out == 64'd0, "R12 data", data_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk over modes, lengths and channel patterns.
        for (int v = 0; v < NV; v++) begin
            ch_inc    = VEC[v].inc;
            len_sel   = VEC[v].len;
            pulse_cnt = VEC[v].pcnt;
            mode      = VEC[v].md;
            case (VEC[v].md)
                2'd1: sync_pulses(1, 6);
                2'd2: begin
                    adc_en = 1'b1;
                    repeat (int'(VEC[v].arg)) @(negedge clk);
                    adc_en = 1'b0;
                end
                2'd3: sync_pulses(((VEC[v].pcnt == 0) ? 1 : int'(VEC[v].pcnt)) + 1,
                                  int'(VEC[v].arg));
                default: ;
            endcase
            wait_valid("R10 table valid");
            check_chans(VEC[v].inc, VEC[v].exp, "R1 table result");
            idle_down();
        end

        // R11: a held read strobe defers the transfer; R4 single shot ends.
        rd_strobe = 1'b1;
        ch_inc    = 4'b1111;
        len_sel   = 2'd1;
        mode      = 2'd1;
        sync_pulses(1, 6);
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (6) @(negedge clk);
        check(valid == 1'b0, "R11 deferred valid", valid, 0);
        check(ch(0) == 16'd5, "R11 held data", ch(0), 5);
        check(busy == 1'b0, "R4 no restart", busy, 0);
        rd_strobe = 1'b0;
        @(negedge clk);
        check(valid == 1'b1, "R11 transfer after read", valid, 1);
        check_chans(4'b1111, 16'd200, "R9 all channels together");

        // R10: a single read strobe clears valid.
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        check(valid == 1'b0, "R10 read clears", valid, 0);

        // R8: the second free-running window is not cumulative.
        len_sel = 2'd0;
        mode    = 2'd0;
        wait_valid("R8 first valid");
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        wait_valid("R8 second valid");
        check_chans(4'b1111, 16'd24, "R8 restart from zero");
        check(busy == 1'b1, "R2 busy back to back", busy, 1);
        idle_down();

        // R3: reserved length code starts nothing in either internal mode.
        len_sel = 2'd3;
        mode    = 2'd0;
        repeat (40) @(negedge clk);
        check(busy == 1'b0, "R3 free reserved", busy, 0);
        mode = 2'd1;
        sync_pulses(1, 6);
        repeat (10) @(negedge clk);
        check(busy == 1'b0, "R3 single reserved", busy, 0);
        check(valid == 1'b0, "R3 no transfer", valid, 0);

        // R7: a long gated window saturates the counting channel.
        len_sel = 2'd0;
        ch_inc  = 4'b0001;
        mode    = 2'd2;
        adc_en  = 1'b1;
        repeat (70000) @(negedge clk);
        adc_en = 1'b0;
        wait_valid("R7 valid");
        check_chans(4'b0001, 16'hFFFF, "R7 saturation");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule